// File: doc/BRIEF.md
# Comparand and Mask Register Unit

This unit holds the search key and the two masks that sit in front of a content-addressable array. The key (the comparand) is 64 bits wide. The first mask also has a foreground copy and a background copy, and one of the two is active at any time. Software loads and reads all three registers through a 16-bit port, one segment at a time. A 2-bit segment index picks the slice: segment k covers bits 16k+15 down to 16k.

The array is split into a compare part and a plain data part. The compare part always starts at bit 0 and is 16, 32, 48 or 64 bits wide. Shifts act only inside that part:

- A comparand shift rotates its bits, so the bit that leaves one end comes back in at the other end.
- A shift of the second mask slides it. The edge bit is copied into its neighbour and nothing wraps around.

The unit drives two compare outputs and one merge output:

- `cmp_value` carries the comparand.
- `cmp_enable` carries a per-bit enable built from whichever mask the compare select names. Mask polarity is inverted: a 0 mask bit means the bit takes part.
- `merge_out` combines a write source with a destination under the mask the merge select names. A 0 mask bit lets the source bit through, and a 1 keeps the destination bit.

The compare array, the storage and the instruction decoding are outside this block.

Top module: `cmr_top`

## Requirements
- R1: After synchronous reset the comparand, both copies of the first mask and the second mask are all zero, and the foreground copy (bank 0) of the first mask is active.
- R2: When `wr_en` is high, the register named by `wr_tgt` (0 comparand, 1 active first mask, 2 second mask) takes `wr_data` into bits 16*`wr_seg`+15..16*`wr_seg` on the next clock edge. Its other segments keep their values.
- R3: `rd_data` shows, in the same cycle, segment `rd_seg` of the register named by `rd_tgt` (same encoding as R2). Target code 3 reads as zero, and a write with target code 3 changes no register.
- R4: `shift_op`=1 (right) with `shift_tgt`=0 rotates the comparand inside the compare part. The compare part is bits 0..W-1, with W=16*(`cam_code`+1). Bit 0 moves to bit W-1. Bits at W and above are unchanged.
- R5: `shift_op`=2 (left) with `shift_tgt`=0 rotates the comparand the other way: bit W-1 moves to bit 0. Bits at W and above are unchanged.
- R6: `shift_op`=1 with `shift_tgt`=1 shifts the second mask right inside the compare part. Bit W-1 keeps its value and is also copied into bit W-2. Nothing wraps, and bits at W and above are unchanged.
- R7: `shift_op`=2 with `shift_tgt`=1 shifts the second mask left inside the compare part. Bit 0 keeps its value and is also copied into bit 1. Nothing wraps, and bits at W and above are unchanged.
- R8: While `wr_en` is high, any shift request is ignored. `shift_op` code 3 is also ignored.
- R9: `bank_wr` loads `bank_val` into the active-bank selector on the next clock edge. First-mask writes, reads, compares and merges use only the active copy, and the inactive copy keeps its contents.
- R10: `cmp_enable` is the bitwise inverse of the mask that `cmp_mask_sel` picks (1 active first mask, 2 second mask). It is all ones for codes 0 and 3.
- R11: Each bit of `merge_out` is the `merge_src` bit where the mask that `merge_sel` picks (same codes as R10) holds 0, and the `merge_dst` bit where that mask holds 1. Codes 0 and 3 pass `merge_src` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment write strobe |
| wr_tgt | input | 2 | Write target register |
| wr_seg | input | 2 | Write segment index |
| wr_data | input | 16 | Write segment data |
| rd_tgt | input | 2 | Read target register |
| rd_seg | input | 2 | Read segment index |
| rd_data | output | 16 | Read segment data |
| shift_op | input | 2 | 0 none, 1 right, 2 left, 3 none |
| shift_tgt | input | 1 | 0 comparand, 1 second mask |
| cam_code | input | 2 | Compare part width code, W=16*(code+1) |
| bank_wr | input | 1 | Load the active-bank selector |
| bank_val | input | 1 | New active bank for the first mask |
| cmp_mask_sel | input | 2 | Mask used for compares |
| merge_sel | input | 2 | Mask used for merges |
| merge_dst | input | 64 | Merge destination value |
| merge_src | input | 64 | Merge source value |
| cmp_value | output | 64 | Comparand |
| cmp_enable | output | 64 | Per-bit compare enable |
| merge_out | output | 64 | Masked merge result |

## Verification
The bench targets the following mistakes and what each would show at the ports:

- **Partition edges at every width code.** A design that wraps at bit 63 regardless of `cam_code` would push bits into the data part, which must stay untouched. A design with an off-by-one limit would lose or duplicate one bit of the comparand.
- **Slide without wrap.** A sliding shift that wrapped like the rotate would pull the far-end bit of the second mask into the edge position instead of keeping the edge bit.
- **Bank swap.** The bench writes one copy, swaps banks and then reads, compares and merges. A design that wrote both copies, or that read the stale copy, would return the wrong segment and the wrong enable.
- **Write and shift together.** A write issued with a shift request must win alone. A design that let the shift through would show a rotated or slid value on the next read.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
    parameter int DATA_W    = 64;
    parameter int SEG_W     = 16;
    parameter int NSEG      = DATA_W / SEG_W;
    parameter int SEG_IDX_W = $clog2(NSEG);

    typedef enum logic [1:0] {TGT_CMP = 2'd0, TGT_M1 = 2'd1, TGT_M2 = 2'd2, TGT_NONE = 2'd3} tgt_e;
    typedef enum logic [1:0] {SH_NONE = 2'd0, SH_RIGHT = 2'd1, SH_LEFT = 2'd2, SH_RSVD = 2'd3} shift_e;
    typedef enum logic [1:0] {MSEL_NONE = 2'd0, MSEL_M1 = 2'd1, MSEL_M2 = 2'd2, MSEL_RSVD = 2'd3} msel_e;

    typedef struct packed {
        logic                 en;
        logic [SEG_IDX_W-1:0] seg;
        logic [SEG_W-1:0]     data;
    } seg_wr_t;

    // Shift inside the compare part [0 .. top]; bits above top are kept.
    // wrap=1 rotates, wrap=0 replicates the edge bit.
    function automatic logic [DATA_W-1:0] shift_part(
        input logic [DATA_W-1:0] v,
        input logic [1:0]        code,
        input logic              right,
        input logic              wrap
    );
        logic [DATA_W-1:0] res;
        int                top;
        top = (int'(code) + 1) * SEG_W - 1;
        res = v;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= top) begin
                if (right) begin
                    if (i == top) res[i] = wrap ? v[0] : v[top];
                    else          res[i] = v[(i + 1) % DATA_W];
                end else begin
                    if (i == 0)   res[i] = wrap ? v[top] : v[0];
                    else          res[i] = v[(i + DATA_W - 1) % DATA_W];
                end
            end
        end
        return res;
    endfunction

    function automatic logic [DATA_W-1:0] pick_mask(
        input msel_e             sel,
        input logic [DATA_W-1:0] m1,
        input logic [DATA_W-1:0] m2
    );
        case (sel)
            MSEL_M1: return m1;
            MSEL_M2: return m2;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/cmr_seg_reg.sv
module cmr_seg_reg
    import cmr_pkg::*;
#(
    parameter bit SHIFTABLE = 1'b1,
    parameter bit WRAP      = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  seg_wr_t           wr,
    input  shift_e            sh,
    input  logic [1:0]        cam_code,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        wr_val = q;
        wr_val[wr.seg*SEG_W +: SEG_W] = wr.data;
    end

    generate
        if (SHIFTABLE) begin : g_shift
            always_comb begin
                nxt = q;
                if (wr.en)                nxt = wr_val;
                else if (sh == SH_RIGHT)  nxt = shift_part(q, cam_code, 1'b1, WRAP);
                else if (sh == SH_LEFT)   nxt = shift_part(q, cam_code, 1'b0, WRAP);
            end
        end else begin : g_fixed
            logic unused_in;
            assign unused_in = ^{sh, cam_code};
            always_comb nxt = wr.en ? wr_val : q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/cmr_mask1_bank.sv
module cmr_mask1_bank
    import cmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seg_wr_t           wr,
    input  logic              bank_wr,
    input  logic              bank_val,
    output logic [DATA_W-1:0] act_q
);
    localparam int NCOPY = 2;

    logic                act;
    logic [DATA_W-1:0]   copy_q [NCOPY];

    generate
        for (genvar c = 0; c < NCOPY; c++) begin : g_copy
            seg_wr_t cw;
            always_comb begin
                cw    = wr;
                cw.en = wr.en && (act == c[0]);
            end
            cmr_seg_reg #(.SHIFTABLE(1'b0), .WRAP(1'b0)) u_reg (
                .clk      (clk),
                .rst      (rst),
                .wr       (cw),
                .sh       (SH_NONE),
                .cam_code (2'b00),
                .q        (copy_q[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          act <= 1'b0;
        else if (bank_wr) act <= bank_val;
    end

    assign act_q = copy_q[act];
endmodule

// File: rtl/cmr_mask_view.sv
module cmr_mask_view
    import cmr_pkg::*;
(
    input  msel_e             cmp_sel,
    input  msel_e             merge_sel,
    input  logic [DATA_W-1:0] m1,
    input  logic [DATA_W-1:0] m2,
    input  logic [DATA_W-1:0] merge_dst,
    input  logic [DATA_W-1:0] merge_src,
    output logic [DATA_W-1:0] cmp_enable,
    output logic [DATA_W-1:0] merge_out
);
    logic [DATA_W-1:0] cmask;
    logic [DATA_W-1:0] wmask;

    always_comb begin
        cmask      = pick_mask(cmp_sel, m1, m2);
        wmask      = pick_mask(merge_sel, m1, m2);
        cmp_enable = ~cmask;
        merge_out  = (merge_src & ~wmask) | (merge_dst & wmask);
    end
endmodule

// File: rtl/cmr_top.sv
module cmr_top
    import cmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_tgt,
    input  logic [SEG_IDX_W-1:0]  wr_seg,
    input  logic [SEG_W-1:0]      wr_data,
    input  logic [1:0]            rd_tgt,
    input  logic [SEG_IDX_W-1:0]  rd_seg,
    output logic [SEG_W-1:0]      rd_data,
    input  logic [1:0]            shift_op,
    input  logic                  shift_tgt,
    input  logic [1:0]            cam_code,
    input  logic                  bank_wr,
    input  logic                  bank_val,
    input  logic [1:0]            cmp_mask_sel,
    input  logic [1:0]            merge_sel,
    input  logic [DATA_W-1:0]     merge_dst,
    input  logic [DATA_W-1:0]     merge_src,
    output logic [DATA_W-1:0]     cmp_value,
    output logic [DATA_W-1:0]     cmp_enable,
    output logic [DATA_W-1:0]     merge_out
);
    seg_wr_t           wr_cmp, wr_m1, wr_m2;
    shift_e            sh_cmp, sh_m2, sh_req;
    logic [DATA_W-1:0] m1_q, m2_q, rd_reg;

    always_comb begin
        wr_cmp = '{en: wr_en && (tgt_e'(wr_tgt) == TGT_CMP), seg: wr_seg, data: wr_data};
        wr_m1  = '{en: wr_en && (tgt_e'(wr_tgt) == TGT_M1),  seg: wr_seg, data: wr_data};
        wr_m2  = '{en: wr_en && (tgt_e'(wr_tgt) == TGT_M2),  seg: wr_seg, data: wr_data};
        sh_req = wr_en ? SH_NONE : shift_e'(shift_op);
        sh_cmp = (shift_tgt == 1'b0) ? sh_req : SH_NONE;
        sh_m2  = (shift_tgt == 1'b1) ? sh_req : SH_NONE;
    end

    cmr_seg_reg #(.SHIFTABLE(1'b1), .WRAP(1'b1)) u_cmp (
        .clk(clk), .rst(rst), .wr(wr_cmp), .sh(sh_cmp), .cam_code(cam_code), .q(cmp_value)
    );

    cmr_seg_reg #(.SHIFTABLE(1'b1), .WRAP(1'b0)) u_m2 (
        .clk(clk), .rst(rst), .wr(wr_m2), .sh(sh_m2), .cam_code(cam_code), .q(m2_q)
    );

    cmr_mask1_bank u_m1 (
        .clk(clk), .rst(rst), .wr(wr_m1), .bank_wr(bank_wr), .bank_val(bank_val), .act_q(m1_q)
    );

    cmr_mask_view u_view (
        .cmp_sel    (msel_e'(cmp_mask_sel)),
        .merge_sel  (msel_e'(merge_sel)),
        .m1         (m1_q),
        .m2         (m2_q),
        .merge_dst  (merge_dst),
        .merge_src  (merge_src),
        .cmp_enable (cmp_enable),
        .merge_out  (merge_out)
    );

    always_comb begin
        case (tgt_e'(rd_tgt))
            TGT_CMP: rd_reg = cmp_value;
            TGT_M1:  rd_reg = m1_q;
            TGT_M2:  rd_reg = m2_q;
            default: rd_reg = '0;
        endcase
        rd_data = rd_reg[rd_seg*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/cmr_top_chk.sv
module cmr_top_chk
    import cmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        shift_op,
    input logic              shift_tgt,
    input logic [1:0]        cam_code,
    input logic [1:0]        cmp_mask_sel,
    input logic [1:0]        merge_sel,
    input logic [DATA_W-1:0] merge_src,
    input logic [DATA_W-1:0] cmp_value,
    input logic [DATA_W-1:0] cmp_enable,
    input logic [DATA_W-1:0] merge_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmp_value == '0));

    // R4
    rot_right_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && shift_op == 2'd1 && !shift_tgt && cam_code == 2'd3)
        |=> (cmp_value == {$past(cmp_value[0]), $past(cmp_value[DATA_W-1:1])}));

    // R5
    rot_left_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && shift_op == 2'd2 && !shift_tgt && cam_code == 2'd3)
        |=> (cmp_value == {$past(cmp_value[DATA_W-2:0]), $past(cmp_value[DATA_W-1])}));

    // R8
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en == 1'b0 && (shift_tgt || shift_op == 2'd0 || shift_op == 2'd3))
        |=> $stable(cmp_value));

    // R10
    enable_none_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_mask_sel == 2'd0 || cmp_mask_sel == 2'd3) |-> (&cmp_enable));

    // R11
    merge_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (merge_sel == 2'd0) |-> (merge_out == merge_src));
endmodule

bind cmr_top cmr_top_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .shift_op(shift_op), .shift_tgt(shift_tgt),
    .cam_code(cam_code), .cmp_mask_sel(cmp_mask_sel), .merge_sel(merge_sel),
    .merge_src(merge_src), .cmp_value(cmp_value), .cmp_enable(cmp_enable),
    .merge_out(merge_out)
);

// File: tb/cmr_top_tb_top.sv
module cmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_tgt, wr_seg, rd_tgt, rd_seg, shift_op, cam_code, cmp_mask_sel, merge_sel;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        shift_tgt, bank_wr, bank_val;
    logic [63:0] merge_dst, merge_src, cmp_value, cmp_enable, merge_out;

    int checks = 0;
    int errors = 0;

    // reference state
    bit [63:0] r_cmp, r_m2;
    bit [63:0] r_m1 [2];
    bit        r_act;

    always #4 clk = ~clk;

    cmr_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_seg(wr_seg),
        .wr_data(wr_data), .rd_tgt(rd_tgt), .rd_seg(rd_seg), .rd_data(rd_data),
        .shift_op(shift_op), .shift_tgt(shift_tgt), .cam_code(cam_code),
        .bank_wr(bank_wr), .bank_val(bank_val), .cmp_mask_sel(cmp_mask_sel),
        .merge_sel(merge_sel), .merge_dst(merge_dst), .merge_src(merge_src),
        .cmp_value(cmp_value), .cmp_enable(cmp_enable), .merge_out(merge_out)
    );

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic bit [63:0] part_m(bit [1:0] code);
        return (code == 2'd3) ? {64{1'b1}} : ((64'd1 << (16 * (int'(code) + 1))) - 64'd1);
    endfunction

    function automatic bit [63:0] ref_shift(bit [63:0] v, bit [1:0] code, bit right, bit rot);
        bit [63:0] m, p, r;
        int w;
        m = part_m(code);
        w = 16 * (int'(code) + 1);
        p = v & m;
        if (right) r = (p >> 1) | (rot ? (64'(p[0]) << (w - 1)) : (p & (64'd1 << (w - 1))));
        else       r = (p << 1) | (rot ? (p >> (w - 1)) : (p & 64'd1));
        return (v & ~m) | (r & m);
    endfunction

    function automatic bit [63:0] sel_mask(bit [1:0] s);
        if (s == 2'd1) return r_m1[r_act];
        if (s == 2'd2) return r_m2;
        return 64'd0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_tgt = 0; wr_seg = 0; wr_data = 0; rd_tgt = 0; rd_seg = 0;
        shift_op = 0; shift_tgt = 0; bank_wr = 0; bank_val = 0;
        cmp_mask_sel = 0; merge_sel = 0;
    endtask

    task automatic model_clock();
        bit [63:0] seg_m;
        seg_m = 64'hFFFF << (16 * int'(wr_seg));
        if (wr_en) begin
            case (wr_tgt)
                2'd0: r_cmp = (r_cmp & ~seg_m) | ((64'(wr_data) << (16 * int'(wr_seg))));
                2'd1: r_m1[r_act] = (r_m1[r_act] & ~seg_m) | ((64'(wr_data) << (16 * int'(wr_seg))));
                2'd2: r_m2 = (r_m2 & ~seg_m) | ((64'(wr_data) << (16 * int'(wr_seg))));
                default: ;
            endcase
        end else if (shift_op == 2'd1 || shift_op == 2'd2) begin
            if (!shift_tgt) r_cmp = ref_shift(r_cmp, cam_code, shift_op == 2'd1, 1'b1);
            else            r_m2  = ref_shift(r_m2,  cam_code, shift_op == 2'd1, 1'b0);
        end
        if (bank_wr) r_act = bank_val;
    endtask

    // inputs set at negedge; compare outputs; then clock once.
    task automatic step(string tag);
        bit [63:0] rd_full, mm;
        #1;
        case (rd_tgt)
            2'd0: rd_full = r_cmp;
            2'd1: rd_full = r_m1[r_act];
            2'd2: rd_full = r_m2;
            default: rd_full = 64'd0;
        endcase
        mm = sel_mask(merge_sel);
        chk({tag, " cmp_value"}, cmp_value, r_cmp);
        chk({tag, " rd_data"}, 64'(rd_data), 64'(rd_full[16 * int'(rd_seg) +: 16]));
        chk({tag, " cmp_enable"}, cmp_enable, ~sel_mask(cmp_mask_sel));
        chk({tag, " merge_out"}, merge_out, (merge_src & ~mm) | (merge_dst & mm));
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic wr(bit [1:0] t, bit [1:0] s, bit [15:0] d, string tag);
        idle(); wr_en = 1; wr_tgt = t; wr_seg = s; wr_data = d;
        step(tag);
    endtask

    task automatic sh(bit tgt, bit [1:0] op, bit [1:0] code, string tag);
        idle(); shift_tgt = tgt; shift_op = op; cam_code = code;
        step(tag);
    endtask

    task automatic rd_all(bit [1:0] t, string tag);
        for (int s = 0; s < 4; s++) begin
            idle(); rd_tgt = t; rd_seg = 2'(s);
            step(tag);
        end
    endtask

    initial begin
        idle();
        cam_code = 0; merge_dst = 64'h0123_4567_89AB_CDEF; merge_src = 64'hFEDC_BA98_7654_3210;
        rst = 1;
        r_cmp = 0; r_m2 = 0; r_m1[0] = 0; r_m1[1] = 0; r_act = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state of every register
        rd_all(2'd0, "R1");
        rd_all(2'd1, "R1");
        rd_all(2'd2, "R1");

        // R2: segment writes, each segment separately
        for (int s = 0; s < 4; s++) wr(2'd0, 2'(s), 16'hA5A0 + 16'(s), "R2");
        wr(2'd0, 2'd2, 16'h8001, "R2");
        rd_all(2'd0, "R2");
        for (int s = 0; s < 4; s++) wr(2'd2, 2'(s), 16'h1234 * 16'(s + 1), "R2");
        rd_all(2'd2, "R3");

        // R3: target 3 write ignored, read zero
        wr(2'd3, 2'd1, 16'hFFFF, "R3");
        rd_all(2'd3, "R3");
        rd_all(2'd0, "R3");

        // R4 / R5: rotate comparand at each width code
        for (int c = 0; c < 4; c++) begin
            sh(1'b0, 2'd1, 2'(c), "R4");
            sh(1'b0, 2'd1, 2'(c), "R4");
            rd_all(2'd0, "R4");
            sh(1'b0, 2'd2, 2'(c), "R5");
            sh(1'b0, 2'd2, 2'(c), "R5");
            sh(1'b0, 2'd2, 2'(c), "R5");
            rd_all(2'd0, "R5");
        end

        // R6 / R7: slide second mask at each width code
        wr(2'd2, 2'd0, 16'h8001, "R6");
        wr(2'd2, 2'd1, 16'h0001, "R6");
        for (int c = 0; c < 4; c++) begin
            sh(1'b1, 2'd1, 2'(c), "R6");
            sh(1'b1, 2'd1, 2'(c), "R6");
            rd_all(2'd2, "R6");
            sh(1'b1, 2'd2, 2'(c), "R7");
            sh(1'b1, 2'd2, 2'(c), "R7");
            rd_all(2'd2, "R7");
        end

        // R8: write together with shift; shift code 3
        idle(); wr_en = 1; wr_tgt = 2'd1; wr_seg = 2'd3; wr_data = 16'h7E7E;
        shift_op = 2'd1; shift_tgt = 1'b0; cam_code = 2'd3;
        step("R8");
        idle(); wr_en = 1; wr_tgt = 2'd2; wr_seg = 2'd0; wr_data = 16'h0F0F;
        shift_op = 2'd2; shift_tgt = 1'b1; cam_code = 2'd1;
        step("R8");
        sh(1'b0, 2'd3, 2'd3, "R8");
        sh(1'b1, 2'd3, 2'd3, "R8");
        rd_all(2'd0, "R8");
        rd_all(2'd2, "R8");

        // R9: bank switch, inactive copy retained
        wr(2'd1, 2'd0, 16'hF00F, "R9");
        idle(); bank_wr = 1; bank_val = 1; step("R9");
        rd_all(2'd1, "R9");
        wr(2'd1, 2'd0, 16'h00FF, "R9");
        idle(); cmp_mask_sel = 2'd1; merge_sel = 2'd1; step("R9");
        idle(); bank_wr = 1; bank_val = 0; step("R9");
        rd_all(2'd1, "R9");

        // R10 / R11: every select code
        for (int s = 0; s < 4; s++) begin
            idle(); cmp_mask_sel = 2'(s); step("R10");
            idle(); merge_sel = 2'(s); step("R11");
        end

        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            idle();
            wr_en = ($urandom % 3) == 0;
            wr_tgt = 2'($urandom); wr_seg = 2'($urandom); wr_data = 16'($urandom);
            rd_tgt = 2'($urandom); rd_seg = 2'($urandom);
            shift_op = 2'($urandom); shift_tgt = 1'($urandom); cam_code = 2'($urandom);
            bank_wr = ($urandom % 8) == 0; bank_val = 1'($urandom);
            cmp_mask_sel = 2'($urandom); merge_sel = 2'($urandom);
            merge_dst = {$urandom, $urandom}; merge_src = {$urandom, $urandom};
            step("R2-mix R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule